// File: doc/BRIEF.md
# Oversampled NRZI Clock-Data Recovery and 5-bit Deserializer

This block recovers bits from an asynchronous NRZI serial line with no analog oscillator. A local clock running at four times the nominal bit rate (500 MHz for a 125 Mbaud line) samples the line through a synchronizer. Each change between adjacent samples marks a transition. A small phase tracker keeps a sampling-phase index and nudges it one position toward the middle of the bit after each transition. Because the index changes by at most one position per bit, a sample interval grows to five clocks or shrinks to three. That is enough to follow a reference that runs faster or slower than the sender.

When the line carries no transitions, the index is frozen and sampling coasts on the last phase. Each recovered sample is turned from NRZI into NRZ: a level change gives a one and no change gives a zero. The NRZ bits are packed five at a time into unframed symbols. The boundary between symbols is wherever the count happens to fall, and framing, code-group decoding and descrambling are left to the logic downstream.

Top module: `cdr_rx`

## Requirements
- R1: While reset is asserted, and after it is released until the first symbol completes, `sym_vld` is 0 and `sym_data` is 0.
- R2: A recovered bit is 1 when the sampled line level differs from the level sampled one bit earlier, and 0 otherwise.
- R3: Every five recovered bits form one symbol. The earliest of the five is in bit 4 and the latest in bit 0. `sym_vld` is high for exactly one clock per symbol, so consecutive strobes are 15 to 25 clocks apart. Every bit sent is eventually delivered.
- R4: `sym_data` changes only in a cycle where `sym_vld` is high, and holds its value between strobes.
- R5: The sampling phase moves by exactly one position (modulo 4) when it moves, and only after a line transition. Consecutive bit samples are 3 to 5 clocks apart.
- R6: A stream whose bit period is 1000 ppm longer than four local clocks is recovered with no bit errors.
- R7: A stream whose bit period is 1000 ppm shorter than four local clocks is recovered with no bit errors.
- R8: Lock is held, with no bit errors, through 64 consecutive bit times that have no line transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, four times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ser_in | input | 1 | Asynchronous NRZI serial line |
| sym_data | output | 5 | Last completed unframed symbol, earliest bit in bit 4 |
| sym_vld | output | 1 | One-clock strobe marking a new value on `sym_data` |

## Verification
Two events can land in the same cycle: the completion of a symbol and a phase correction that stretches or shrinks a sample interval. A stream that drifts against the local clock forces the phase index to wrap again and again, so some symbols are completed on a shortened or lengthened bit interval. The scoreboard compares every delivered bit against the bits that were sent. It also checks the spacing between strobes and confirms that `sym_data` held steady between them, so a miscounted, dropped or doubled bit around a wrap shows up as a bit mismatch or a strobe-gap error.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
  // One recovered line sample: strobe marks the cycle the bit is taken.
  typedef struct packed {
    logic stb;
    logic val;
  } rbit_t;
endpackage

// File: rtl/cdr_sync.sv
module cdr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rst_n_o,
  output logic dout
);
  logic [STAGES-1:0] rs_q;
  logic [STAGES-1:0] ds_q;

  // reset: asserted at once, removed after STAGES clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[STAGES-2:0], 1'b1};
  end

  // line synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ds_q <= '0;
    else        ds_q <= {ds_q[STAGES-2:0], din};
  end

  assign rst_n_o = rs_q[STAGES-1];
  assign dout    = ds_q[STAGES-1];
endmodule

// File: rtl/cdr_phase.sv
module cdr_phase
  import cdr_pkg::*;
#(
  parameter int OSR = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  smp,
  output rbit_t rbit
);
  localparam int PW   = $clog2(OSR);
  localparam int HALF = OSR / 2;
  localparam int QW   = $clog2(2 * OSR + 1);

  logic [PW-1:0] cnt_q, cnt_d, ph_q, ph_d, tgt_q, tgt_d;
  logic          pend_q, pend_d, last_q;
  logic          edge_w, upd_pt, eff_v;
  logic [PW-1:0] eff_t, diff;

  always_comb begin
    edge_w = smp ^ last_q;
    upd_pt = (cnt_q == ph_q + PW'(HALF));
    eff_v  = edge_w | pend_q;
    eff_t  = edge_w ? cnt_q + PW'(HALF) : tgt_q;
    diff   = eff_t - ph_q;
    cnt_d  = cnt_q + PW'(1);
    ph_d   = ph_q;
    pend_d = pend_q;
    tgt_d  = tgt_q;
    if (upd_pt) begin
      // correction point sits half a bit away from the sample point
      pend_d = 1'b0;
      if (eff_v && diff != '0)
        ph_d = (diff > PW'(HALF)) ? ph_q - PW'(1) : ph_q + PW'(1);
    end else if (edge_w) begin
      pend_d = 1'b1;
      tgt_d  = cnt_q + PW'(HALF);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ph_q   <= '0;
      tgt_q  <= '0;
      pend_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      ph_q   <= ph_d;
      tgt_q  <= tgt_d;
      pend_q <= pend_d;
      last_q <= smp;
    end
  end

  assign rbit.stb = (cnt_q == ph_q);
  assign rbit.val = smp;

  // checker state: cycles since last edge and since last bit sample
  logic [QW-1:0] quiet_q, gap_q;
  logic          seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_q <= '0;
      gap_q   <= '0;
      seen_q  <= 1'b0;
    end else begin
      if (edge_w)                   quiet_q <= '0;
      else if (quiet_q < QW'(OSR))  quiet_q <= quiet_q + QW'(1);
      if (rbit.stb)                 gap_q <= QW'(1);
      else if (gap_q < QW'(2*OSR))  gap_q <= gap_q + QW'(1);
      if (rbit.stb)                 seen_q <= 1'b1;
    end
  end

  p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ph_q) |-> (ph_q == $past(ph_q) + PW'(1)) || (ph_q == $past(ph_q) - PW'(1)));

  p_hold_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_q >= QW'(OSR) && !edge_w) |=> $stable(ph_q));

  p_bit_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rbit.stb && seen_q) |-> (gap_q >= QW'(OSR-1) && gap_q <= QW'(OSR+1)));
endmodule

// File: rtl/cdr_deser.sv
module cdr_deser
  import cdr_pkg::*;
#(
  parameter int SYM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rbit_t            rbit,
  output logic [SYM_W-1:0] sym_data,
  output logic             sym_vld
);
  localparam int CW = $clog2(SYM_W);

  logic             prev_q, prev_d, nrz;
  logic [SYM_W-2:0] sr_q, sr_d;
  logic [CW-1:0]    n_q, n_d;
  logic [SYM_W-1:0] dat_q, dat_d;
  logic             vld_q, vld_d;

  always_comb begin
    nrz    = rbit.val ^ prev_q;
    prev_d = prev_q;
    sr_d   = sr_q;
    n_d    = n_q;
    dat_d  = dat_q;
    vld_d  = 1'b0;
    if (rbit.stb) begin
      prev_d = rbit.val;
      if (n_q == CW'(SYM_W-1)) begin
        dat_d = {sr_q, nrz};
        vld_d = 1'b1;
        n_d   = '0;
      end else begin
        sr_d = {sr_q[SYM_W-3:0], nrz};
        n_d  = n_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      sr_q   <= '0;
      n_q    <= '0;
      dat_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      sr_q   <= sr_d;
      n_q    <= n_d;
      dat_q  <= dat_d;
      vld_q  <= vld_d;
    end
  end

  assign sym_data = dat_q;
  assign sym_vld  = vld_q;

  p_vld_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sym_vld |=> !sym_vld);

  p_vld_needs_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sym_vld |-> $past(rbit.stb));

  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_vld |-> $stable(sym_data));
endmodule

// File: rtl/cdr_rx.sv
module cdr_rx
  import cdr_pkg::*;
#(
  parameter int OSR    = 4,
  parameter int SYM_W  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  output logic [SYM_W-1:0] sym_data,
  output logic             sym_vld
);
  logic  rst_n_i;
  logic  smp;
  rbit_t rbit;

  cdr_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ser_in), .rst_n_o(rst_n_i), .dout(smp)
  );

  cdr_phase #(.OSR(OSR)) u_phase (
    .clk(clk), .rst_n(rst_n_i), .smp(smp), .rbit(rbit)
  );

  cdr_deser #(.SYM_W(SYM_W)) u_deser (
    .clk(clk), .rst_n(rst_n_i), .rbit(rbit), .sym_data(sym_data), .sym_vld(sym_vld)
  );
endmodule

// File: tb/sim_cdr_rx.sv
`timescale 1ns/1ps
module sim_cdr_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_in = 1'b0;
  logic [4:0] sym_data;
  logic       sym_vld;

  always #2 clk = ~clk;  // 250 MHz

  cdr_rx u0 (.clk(clk), .rst_n(rst_n), .ser_in(ser_in), .sym_data(sym_data), .sym_vld(sym_vld));

  typedef struct { bit b; string tag; } exp_t;
  exp_t q[$];

  int   errs = 0, checks = 0;
  bit   done = 0;
  real  bitp = 16.0;
  bit   line = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic send(input bit b, input bit push, input string tag);
    if (b) line = ~line;
    ser_in = line;
    if (push) q.push_back('{b, tag});
    #(bitp);
  endtask

  function automatic bit nxt();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // monitor / scoreboard
  int   ones = 0, gap = 0;
  bit   started = 0, seen = 0;
  logic [4:0] last_data = '0;

  task automatic take(input bit b);
    if (!started) begin
      if (b) ones++;
      else if (ones >= 8) begin started = 1; cmp(b); end
      else ones = 0;
    end else cmp(b);
  endtask

  task automatic cmp(input bit b);
    exp_t e;
    if (q.size() == 0) return;  // trailing pad bits
    e = q.pop_front();
    chk(b == e.b, e.tag, "recovered bit", b, e.b);
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      ones = 0; started = 0; seen = 0; gap = 0; last_data = '0;
    end else begin
      gap++;
      if (sym_vld) begin
        if (seen) chk(gap >= 15 && gap <= 25, "R3", "strobe gap", gap, 20);
        seen = 1; gap = 0;
        for (int i = 4; i >= 0; i--) take(sym_data[i]);
      end else begin
        chk(sym_data === last_data, "R4", "data held", sym_data, last_data);
      end
      last_data = sym_data;
    end
  end

  task automatic run(input real bp, input string tag);
    bitp = bp;
    rst_n = 1'b0;
    q.delete();
    line = 0; ser_in = 0;
    repeat (3) @(negedge clk);
    chk(sym_vld === 1'b0 && sym_data === 5'd0, "R1", "in reset", {sym_vld, sym_data}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sym_vld === 1'b0 && sym_data === 5'd0, "R1", "after release", {sym_vld, sym_data}, 0);
    for (int i = 0; i < 8;  i++) send(0, 0, tag);   // idle
    for (int i = 0; i < 24; i++) send(1, 0, tag);   // preamble: edge every bit
    send(0, 1, tag);                                // payload start marker
    for (int i = 0; i < 300; i++) send(nxt(), 1, tag);
    for (int i = 0; i < 64; i++) send(0, 1, "R8"); // no transitions
    send(1, 1, "R8");
    for (int i = 0; i < 300; i++) send(nxt(), 1, tag);
    for (int i = 0; i < 12; i++) send(1, 0, tag);  // pad to flush
    repeat (40) @(negedge clk);
    chk(q.size() == 0, "R3", "undelivered bits", q.size(), 0);
  endtask

  initial begin
    run(16.0,   "R2");     // nominal rate, NRZI decode
    run(16.016, "R5 R6");  // slow stream, phase steps and wraps
    run(15.984, "R5 R7");  // fast stream, phase steps and wraps
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule